// File: doc/BRIEF.md
# Station address configuration port

This block holds the station's own 48-bit unicast address and a 64-bit multicast hash filter, and lets software load both through a narrow byte-wide register port. Neither store is mapped as a wide word. Software first writes a change request to a control register. It polls that register until the busy flag drops, then writes a select code that chooses the physical address or the filter as the target. After that it streams the bytes one by one into that target's data register, and an internal pointer advances on each accepted write.

Both stored values are presented continuously on parallel outputs, so the receive address matcher and the hash filter logic can use them directly. Reset clears both stores, the pointer and the target choice. Reads are combinational on the register index.

Top module: `addr_cfg_port`

## Requirements
- R1: After reset, `stn_addr` and `addr_filter` are all zero, and a read of the control register (index 18) returns 0x00.
- R2: A control write with bit 7 (0x80) set raises the busy flag. The flag reads back as bit 7 of the control register right after that clock edge and on the next edge, and it reads zero from the second edge onward. Select bits carried in the same write are ignored.
- R3: A control write that arrives while busy is set has no effect on the target or on the pointer.
- R4: A control write with bit 2 (0x04) set and bit 7 clear selects the physical address. The next six writes to index 21 fill address bytes 0 to 5 in order, and byte k sits at `stn_addr[8k+7:8k]`. Byte 0 is the first octet sent on the wire.
- R5: A control write with bit 1 (0x02) set and bit 7 clear selects the filter. The next eight writes to index 20 fill filter bytes 0 to 7 in order, and byte k sits at `addr_filter[8k+7:8k]`.
- R6: Data writes beyond the last byte of the selected store are ignored. Selecting the target again restarts the fill at byte 0.
- R7: A write to the data register of the store that is not selected changes neither store.
- R8: When bit 2 and bit 1 are both set in one select write, the physical address is selected.
- R9: Each accepted data write changes exactly one byte. Bytes not yet written keep their earlier value.
- R10: Bit 7 of a control register read is the busy flag and its other bits read zero. A read of any other index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle write strobe |
| cfg_idx | input | 5 | Register index for the read or write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_idx` |
| stn_addr | output | 48 | Stored physical address, byte 0 in bits 7:0 |
| addr_filter | output | 64 | Stored hash filter, byte 0 in bits 7:0 |

## Verification
The bench builds the block with its default parameters: six address bytes, eight filter bytes, a two-cycle busy window and control, filter and address indices 18, 20 and 21. With these values a full fill of both stores, the write past the end of each store, and the exact cycle on which busy drops are all reached within a few dozen clocks. Because the busy window is two cycles long, the multi-cycle counter variant is built rather than the single-flop one. That gives a real window in which to test a select write made while busy.

// File: rtl/sacp_pkg.sv
package sacp_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_PHYS = 2'd1,
      TGT_FILT = 2'd2
   } sacp_tgt_e;

   localparam int CHG_BIT  = 7;
   localparam int PSEL_BIT = 2;
   localparam int FSEL_BIT = 1;
endpackage

// File: rtl/sacp_busy_timer.sv
module sacp_busy_timer #(
   parameter int BUSY_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (BUSY_CYCLES < 1) begin : g_bad
         $error("BUSY_CYCLES must be at least 1");
      end

      if (BUSY_CYCLES == 1) begin : g_flop
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign busy = busy_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (start)           cnt_q <= LOAD;
            else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
         end
         assign busy = (cnt_q != '0);

         AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !start) |=> (cnt_q < $past(cnt_q))); // R2
      end
   endgenerate

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R2
endmodule

// File: rtl/sacp_byte_store.sv
module sacp_byte_store #(
   parameter int NUM_BYTES = 6,
   parameter int BYTE_W    = 8,
   localparam int SEL_W    = $clog2(NUM_BYTES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [SEL_W-1:0]            wr_sel,
   input  logic [BYTE_W-1:0]           wr_data,
   output logic [NUM_BYTES*BYTE_W-1:0] q
);
   generate
      if (NUM_BYTES < 2) begin : g_bad
         $error("NUM_BYTES must be at least 2");
      end

      for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
         logic [BYTE_W-1:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= '0;
            else if (wr_en && (wr_sel == SEL_W'(b)))
               byte_q <= wr_data;
         end
         assign q[b*BYTE_W +: BYTE_W] = byte_q;
      end
   endgenerate

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_sel) < NUM_BYTES)); // R6

   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q)); // R9
endmodule

// File: rtl/sacp_load_seq.sv
module sacp_load_seq
   import sacp_pkg::*;
#(
   parameter int PHYS_BYTES = 6,
   parameter int FILT_BYTES = 8,
   localparam int MAXB  = (PHYS_BYTES > FILT_BYTES) ? PHYS_BYTES : FILT_BYTES,
   localparam int PTR_W = $clog2(MAXB + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic             chg_bit,
   input  logic             psel_bit,
   input  logic             fsel_bit,
   input  logic             busy,
   input  logic             phys_data_wr,
   input  logic             filt_data_wr,
   output sacp_tgt_e        target,
   output logic [PTR_W-1:0] ptr,
   output logic             phys_we,
   output logic             filt_we
);
   localparam logic [PTR_W-1:0] PHYS_END = PTR_W'(PHYS_BYTES);
   localparam logic [PTR_W-1:0] FILT_END = PTR_W'(FILT_BYTES);

   sacp_tgt_e        tgt_q;
   logic [PTR_W-1:0] ptr_q;
   logic             sel_ok;

   assign sel_ok  = ctrl_wr && !busy && !chg_bit && (psel_bit || fsel_bit);
   assign phys_we = phys_data_wr && (tgt_q == TGT_PHYS) && (ptr_q < PHYS_END);
   assign filt_we = filt_data_wr && (tgt_q == TGT_FILT) && (ptr_q < FILT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= TGT_NONE;
         ptr_q <= '0;
      end else if (sel_ok) begin
         tgt_q <= psel_bit ? TGT_PHYS : TGT_FILT;
         ptr_q <= '0;
      end else if (phys_we || filt_we) begin
         ptr_q <= ptr_q + PTR_W'(1);
      end
   end

   assign target = tgt_q;
   assign ptr    = ptr_q;

   AST_SEL_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && busy) |=> ($stable(ptr_q) && $stable(tgt_q))); // R3

   AST_PHYS_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q == TGT_PHYS) |-> (ptr_q <= PHYS_END)); // R6

   AST_FILT_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q == TGT_FILT) |-> (ptr_q <= FILT_END)); // R6

   AST_ONE_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phys_we, filt_we})); // R7

   AST_BOTH_SEL_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && psel_bit && fsel_bit) |=> (tgt_q == TGT_PHYS)); // R8
endmodule

// File: rtl/addr_cfg_port.sv
module addr_cfg_port
   import sacp_pkg::*;
#(
   parameter int IDX_W       = 5,
   parameter int PHYS_BYTES  = 6,
   parameter int FILT_BYTES  = 8,
   parameter int BUSY_CYCLES = 2,
   parameter int CTRL_IDX    = 18,
   parameter int FILT_IDX    = 20,
   parameter int PHYS_IDX    = 21
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [IDX_W-1:0]        cfg_idx,
   input  logic [7:0]              cfg_wdata,
   output logic [7:0]              cfg_rdata,
   output logic [PHYS_BYTES*8-1:0] stn_addr,
   output logic [FILT_BYTES*8-1:0] addr_filter
);
   localparam int MAXB   = (PHYS_BYTES > FILT_BYTES) ? PHYS_BYTES : FILT_BYTES;
   localparam int PTR_W  = $clog2(MAXB + 1);
   localparam int PSEL_W = $clog2(PHYS_BYTES);
   localparam int FSEL_W = $clog2(FILT_BYTES);
   localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(CTRL_IDX);
   localparam logic [IDX_W-1:0] I_FILT = IDX_W'(FILT_IDX);
   localparam logic [IDX_W-1:0] I_PHYS = IDX_W'(PHYS_IDX);

   generate
      if (CTRL_IDX == FILT_IDX || CTRL_IDX == PHYS_IDX || FILT_IDX == PHYS_IDX) begin : g_bad_idx
         $error("register indices must be distinct");
      end
      if (PHYS_IDX >= (1 << IDX_W) || FILT_IDX >= (1 << IDX_W) || CTRL_IDX >= (1 << IDX_W)) begin : g_bad_w
         $error("register index does not fit IDX_W");
      end
   endgenerate

   logic             ctrl_wr, phys_data_wr, filt_data_wr;
   logic             busy, chg_start, phys_we, filt_we;
   sacp_tgt_e        target;
   logic [PTR_W-1:0] ptr;

   assign ctrl_wr      = cfg_wr && (cfg_idx == I_CTRL);
   assign phys_data_wr = cfg_wr && (cfg_idx == I_PHYS);
   assign filt_data_wr = cfg_wr && (cfg_idx == I_FILT);
   assign chg_start    = ctrl_wr && cfg_wdata[CHG_BIT];

   sacp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (chg_start),
      .busy  (busy)
   );

   sacp_load_seq #(.PHYS_BYTES(PHYS_BYTES), .FILT_BYTES(FILT_BYTES)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr      (ctrl_wr),
      .chg_bit      (cfg_wdata[CHG_BIT]),
      .psel_bit     (cfg_wdata[PSEL_BIT]),
      .fsel_bit     (cfg_wdata[FSEL_BIT]),
      .busy         (busy),
      .phys_data_wr (phys_data_wr),
      .filt_data_wr (filt_data_wr),
      .target       (target),
      .ptr          (ptr),
      .phys_we      (phys_we),
      .filt_we      (filt_we)
   );

   sacp_byte_store #(.NUM_BYTES(PHYS_BYTES), .BYTE_W(8)) u_phys (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (phys_we),
      .wr_sel  (ptr[PSEL_W-1:0]),
      .wr_data (cfg_wdata),
      .q       (stn_addr)
   );

   sacp_byte_store #(.NUM_BYTES(FILT_BYTES), .BYTE_W(8)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (filt_we),
      .wr_sel  (ptr[FSEL_W-1:0]),
      .wr_data (cfg_wdata),
      .q       (addr_filter)
   );

   always_comb begin
      cfg_rdata = '0;
      if (cfg_idx == I_CTRL) cfg_rdata[CHG_BIT] = busy;
   end

   AST_PHYS_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phys_data_wr && target == TGT_PHYS && ptr == PTR_W'(PHYS_BYTES)) |=> $stable(stn_addr)); // R6

   AST_WRONG_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_data_wr && target != TGT_FILT) |=> $stable(addr_filter)); // R7

   AST_READ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[6:0] == 7'd0)); // R10
endmodule

// File: tb/test_addr_cfg_port.sv
module test_addr_cfg_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [4:0]  cfg_idx = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [47:0] stn_addr;
   logic [63:0] addr_filter;

   int n_tests = 0;
   int n_fail  = 0;

   localparam logic [4:0] CTRL = 5'd18;
   localparam logic [4:0] FIDX = 5'd20;
   localparam logic [4:0] PIDX = 5'd21;

   // stimulus table: {index, data}; expected stores follow from R4/R5 order
   localparam logic [12:0] SEQ [18] = '{
      {CTRL, 8'h80}, {CTRL, 8'h04},
      {PIDX, 8'h02}, {PIDX, 8'h1A}, {PIDX, 8'h3C},
      {PIDX, 8'h4D}, {PIDX, 8'h5E}, {PIDX, 8'h6F},
      {CTRL, 8'h80}, {CTRL, 8'h02},
      {FIDX, 8'h11}, {FIDX, 8'h22}, {FIDX, 8'h33}, {FIDX, 8'h44},
      {FIDX, 8'h55}, {FIDX, 8'h66}, {FIDX, 8'h77}, {FIDX, 8'h88}
   };

   addr_cfg_port i_addr_cfg_port (
      .clk, .rst_n, .cfg_wr, .cfg_idx, .cfg_wdata, .cfg_rdata,
      .stn_addr, .addr_filter
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] idx, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] idx, output logic [7:0] d);
      cfg_idx = idx;
      #1;
      d = cfg_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] v;
      for (int i = 0; i < 20; i++) begin
         rd(CTRL, v);
         if (v[7] == 1'b0) break;
         @(negedge clk);
      end
   endtask

   initial begin
      #2_000_000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  v;
      logic [47:0] exp_s;
      logic [63:0] exp_f;
      logic [47:0] snap_s;
      logic [63:0] snap_f;
      int pk;
      int fk;
      exp_s = '0; exp_f = '0; pk = 0; fk = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 stn_addr", {16'd0, stn_addr}, 64'd0);
      chk("R1 filter", addr_filter, 64'd0);
      rd(CTRL, v);
      chk("R1 ctrl read", {56'd0, v}, 64'd0);

      // table walk: R4 R5 R9
      for (int e = 0; e < 18; e++) begin
         wr(SEQ[e][12:8], SEQ[e][7:0]);
         if (SEQ[e][12:8] == CTRL && SEQ[e][7]) wait_idle();
         if (SEQ[e][12:8] == PIDX) begin
            exp_s[pk*8 +: 8] = SEQ[e][7:0];
            pk++;
            chk("R4 R9 phys byte fill", {16'd0, stn_addr}, {16'd0, exp_s});
         end
         if (SEQ[e][12:8] == FIDX) begin
            exp_f[fk*8 +: 8] = SEQ[e][7:0];
            fk++;
            chk("R5 R9 filter byte fill", addr_filter, exp_f);
         end
      end
      chk("R4 final address", {16'd0, stn_addr}, 64'h0000_6F5E_4D3C_1A02);
      chk("R5 final filter", addr_filter, 64'h8877_6655_4433_2211);

      // R6 filter full: ninth byte ignored
      wr(FIDX, 8'h99);
      chk("R6 filter overflow ignored", addr_filter, 64'h8877_6655_4433_2211);

      // R2 busy timing, and select in the same write ignored
      wr(CTRL, 8'h84);
      rd(CTRL, v);
      chk("R2 busy after edge 1", {56'd0, v}, 64'h80);
      @(negedge clk); rd(CTRL, v);
      chk("R2 busy after edge 2", {56'd0, v}, 64'h80);
      @(negedge clk); rd(CTRL, v);
      chk("R2 busy cleared", {56'd0, v}, 64'h00);
      wr(PIDX, 8'hC3);
      chk("R2 select with change ignored", {16'd0, stn_addr}, 64'h0000_6F5E_4D3C_1A02);

      // R3 select while busy ignored
      wr(CTRL, 8'h80);
      wr(CTRL, 8'h04);
      wait_idle();
      wr(PIDX, 8'hC4);
      chk("R3 select while busy ignored", {16'd0, stn_addr}, 64'h0000_6F5E_4D3C_1A02);

      // R8 both select bits pick physical; R6 reselect restarts at byte 0
      wr(CTRL, 8'h06);
      wr(PIDX, 8'hAA);
      chk("R8 R6 both bits select phys, byte 0", {16'd0, stn_addr}, 64'h0000_6F5E_4D3C_1AAA);

      // R7 wrong data register ignored while phys selected
      snap_f = addr_filter;
      wr(FIDX, 8'hEE);
      chk("R7 filter untouched", addr_filter, snap_f);

      // R6 fill remaining phys bytes then overflow
      wr(PIDX, 8'hB1); wr(PIDX, 8'hB2); wr(PIDX, 8'hB3); wr(PIDX, 8'hB4); wr(PIDX, 8'hB5);
      chk("R4 refill", {16'd0, stn_addr}, 64'h0000_B5B4_B3B2_B1AA);
      snap_s = stn_addr;
      wr(PIDX, 8'h77);
      chk("R6 phys overflow ignored", {16'd0, stn_addr}, {16'd0, snap_s});

      // R10 reads of other indices are zero
      rd(PIDX, v);
      chk("R10 data index read zero", {56'd0, v}, 64'd0);
      rd(CTRL, v);
      chk("R10 ctrl idle read", {56'd0, v}, 64'd0);

      // R1 reset clears again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset clears address", {16'd0, stn_addr}, 64'd0);
      chk("R1 reset clears filter", addr_filter, 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule